// File: doc/BRIEF.md
# Burst-Clocked Serial Converter Reader

This controller sits on the host side of a successive-approximation converter that returns each 16-bit result over a serial line. On a user request it selects the converter and pulses the read/convert line low to start a conversion. It then waits for the converter's busy flag to fall and to rise again. Only after that does it drive a burst of data-clock pulses, shifting the returned bits into a parallel register. The data clock stays parked low for the whole conversion, because edges on the digital pins during conversion, and most of all late in it, corrupt the result.

The request side is a valid/ready handshake. A request is taken only on a cycle where both `start_valid` and `start_ready` are high, and `start_ready` stays low for the whole transaction. The result side has no back-pressure: `res_valid` is a one-cycle strobe, and the host must take `res_data` in that cycle. Capture uses the rising edge of the data clock, so each word costs one clock pulse more than the word has bits. The converter presents its MSB after the first falling edge and its LSB after the sixteenth.

Top module: `adc_burst_reader`

## Requirements
- R1: After reset, `start_ready` is 1, `cs_n` is 1, `rc_n` is 1, `dclk` is 0 and `res_valid` is 0.
- R2: A request is accepted only when `start_valid` and `start_ready` are both high. `start_ready` then stays low until the cycle after the `res_valid` strobe. A `start_valid` pulse while `start_ready` is low is dropped and starts no conversion.
- R3: After acceptance, `rc_n` is low for exactly CONV_LOW cycles, starting the next cycle. `cs_n` is low from that same cycle through the `res_valid` cycle, and it is low whenever `rc_n` is low or `dclk` is high.
- R4: `dclk` stays low while `conv_busy_n` is low. No `dclk` edge occurs until the two-flop-synchronised busy has been seen low and then high. The first rising edge comes HALF_CYC+3 cycles after the cycle in which `conv_busy_n` is first seen high.
- R5: Each word gets exactly 17 rising edges of `dclk`. Every high phase lasts HALF_CYC system clocks, and so does every low phase between pulses.
- R6: `sdata` is sampled at rising edges 2 through 17 and shifted in MSB first, so edge 2 gives bit 15 and edge 17 gives bit 0. The value seen at rising edge 1 never reaches `res_data`.
- R7: `res_valid` is high for exactly one cycle: the cycle right after the 17th high phase ends. `res_data` holds the captured word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Conversion request |
| start_ready | output | 1 | Controller idle, request can be taken |
| conv_busy_n | input | 1 | Converter busy flag, low while converting |
| sdata | input | 1 | Serial data from converter |
| cs_n | output | 1 | Converter select, active low |
| rc_n | output | 1 | Read/convert control, low starts conversion |
| dclk | output | 1 | Burst data clock, rests low |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Captured result word |

## Verification
Every result has a fixed due cycle, counted from what the bench samples at falling clock edges:
- `rc_n` is low for CONV_LOW samples after acceptance.
- The first `dclk` high is seen HALF_CYC+3 samples after busy is first seen high.
- Each high phase spans HALF_CYC samples.
- `res_valid` is seen in the sample directly after the last sample with `dclk` high.

The bench converter model drives a junk 1 before the first falling edge and after the LSB. An all-zero word therefore shows that edge 1 is discarded. A scoreboard queue pairs each strobe with the word the driver queued, and counters check the pulse count, the timing, and the dropped request.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_READ,
    ST_DONE
  } rd_state_e;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/adc_rd_clkgen.sv
module adc_rd_clkgen #(
  parameter int HALF_CYC = 4,
  parameter int PULSES   = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic dclk,
  output logic capture,
  output logic last_fall
);
  localparam int PW = $clog2(HALF_CYC + 1);
  localparam int CW = $clog2(PULSES + 1);

  logic [PW-1:0] ph;
  logic [CW-1:0] rises;
  logic          toggle;

  assign toggle    = run && (ph == PW'(HALF_CYC - 1));
  assign capture   = toggle && !dclk && (rises != '0);
  assign last_fall = toggle && dclk && (rises == CW'(PULSES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      dclk  <= 1'b0;
      rises <= '0;
    end else if (!run) begin
      ph    <= '0;
      dclk  <= 1'b0;
      rises <= '0;
    end else if (toggle) begin
      ph   <= '0;
      dclk <= ~dclk;
      if (!dclk) rises <= rises + 1'b1;
    end else begin
      ph <= ph + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              din,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word <= '0;
    else if (clr) word <= '0;
    else if (en)  word <= {word[WORD_W-2:0], din};
  end
endmodule

// File: rtl/adc_burst_reader.sv
module adc_burst_reader
  import adc_rd_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int HALF_CYC = 4,
  parameter int CONV_LOW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              conv_busy_n,
  input  logic              sdata,
  output logic              cs_n,
  output logic              rc_n,
  output logic              dclk,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_data
);
  localparam int PULSES = WORD_W + 1;
  localparam int KW     = $clog2(CONV_LOW + 1);

  rd_state_e     state;
  logic [KW-1:0] conv_cnt;
  logic          busy_s;
  logic          accept;
  logic          capture;
  logic          last_fall;

  assign start_ready = (state == ST_IDLE);
  assign accept      = start_valid && start_ready;
  assign res_valid   = (state == ST_DONE);

  adc_rd_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(conv_busy_n), .q(busy_s)
  );

  adc_rd_clkgen #(.HALF_CYC(HALF_CYC), .PULSES(PULSES)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(state == ST_READ),
    .dclk(dclk), .capture(capture), .last_fall(last_fall)
  );

  adc_rd_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(capture),
    .din(sdata), .word(res_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      conv_cnt <= '0;
      cs_n     <= 1'b1;
      rc_n     <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_CONV;
          cs_n     <= 1'b0;
          rc_n     <= 1'b0;
          conv_cnt <= '0;
        end
        ST_CONV: begin
          if (conv_cnt == KW'(CONV_LOW - 1)) begin
            rc_n  <= 1'b1;
            state <= ST_WAIT_LO;
          end else begin
            conv_cnt <= conv_cnt + 1'b1;
          end
        end
        ST_WAIT_LO: if (!busy_s) state <= ST_WAIT_HI;
        ST_WAIT_HI: if (busy_s)  state <= ST_READ;
        ST_READ:    if (last_fall) state <= ST_DONE;
        ST_DONE: begin
          cs_n  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_burst_reader_chk.sv
module adc_burst_reader_chk #(
  parameter int WORD_W   = 16,
  parameter int HALF_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start_valid,
  input logic start_ready,
  input logic conv_busy_n,
  input logic cs_n,
  input logic rc_n,
  input logic dclk,
  input logic res_valid
);
  logic [15:0] hi_run;
  logic [7:0]  rise_cnt;
  logic        dclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run   <= '0;
      rise_cnt <= '0;
      dclk_d   <= 1'b0;
    end else begin
      dclk_d <= dclk;
      hi_run <= dclk ? hi_run + 1'b1 : '0;
      if (start_valid && start_ready) rise_cnt <= '0;
      else if (dclk && !dclk_d)       rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_DCLK_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_busy_n |-> !dclk); // R4
  AST_SEL_DURING_RC: assert property (@(posedge clk) disable iff (!rst_n)
    (!rc_n || dclk) |-> !cs_n); // R3
  AST_NOT_READY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rc_n || dclk || res_valid) |-> !start_ready); // R2
  AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dclk) |-> (hi_run == 16'(HALF_CYC))); // R5
  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (rise_cnt == 8'(WORD_W + 1))); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R7
endmodule

bind adc_burst_reader adc_burst_reader_chk #(.WORD_W(WORD_W), .HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .conv_busy_n(conv_busy_n), .cs_n(cs_n), .rc_n(rc_n), .dclk(dclk),
  .res_valid(res_valid)
);

// File: tb/adc_burst_reader_tb_top.sv
module adc_burst_reader_tb_top;
  localparam int HALF     = 4;
  localparam int CONV_LOW = 3;
  localparam int BUSY_LEN = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic        conv_busy_n = 1'b1;
  logic        sdata = 1'b1;
  logic        cs_n, rc_n, dclk, res_valid;
  logic [15:0] res_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  logic [15:0] model_word = '0;
  int bit_idx = 0;
  int n_words = 0;

  always #5 clk = ~clk;

  adc_burst_reader #(.WORD_W(16), .HALF_CYC(HALF), .CONV_LOW(CONV_LOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .conv_busy_n(conv_busy_n), .sdata(sdata), .cs_n(cs_n), .rc_n(rc_n),
    .dclk(dclk), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: busy pulse after read/convert falls
  always @(negedge rc_n) if (rst_n) begin
    bit_idx = 0;
    sdata <= 1'b1;
    repeat (2) @(posedge clk);
    conv_busy_n <= 1'b0;
    repeat (BUSY_LEN) @(posedge clk);
    conv_busy_n <= 1'b1;
  end

  // bits presented after each falling data-clock edge, junk 1 otherwise
  always @(negedge dclk) if (rst_n) begin
    sdata <= (bit_idx < 16) ? model_word[15 - bit_idx] : 1'b1;
    bit_idx++;
  end

  // monitor / scoreboard
  int cyc = 0, busy_hi_cyc = 0, last_hi = 0, hi_run = 0, lo_run = 0;
  int rises = 0, rc_falls = 0, quiet_viol = 0, cs_viol = 0;
  logic p_dclk = 1'b0, p_rc = 1'b1, p_busy = 1'b1;
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (conv_busy_n && !p_busy) busy_hi_cyc = cyc;
    if (!rc_n && p_rc) begin rises = 0; rc_falls++; end
    if (!rc_n) lo_run++;
    else if (!p_rc) begin
      check(lo_run == CONV_LOW, "R3 rc_n low width", lo_run, CONV_LOW);
      lo_run = 0;
    end
    if ((!rc_n || dclk) && cs_n) cs_viol++;
    if (!conv_busy_n && dclk) quiet_viol++;
    if (dclk && !p_dclk) begin
      rises++;
      if (rises == 1)
        check(cyc - busy_hi_cyc == HALF + 3, "R4 first edge delay", cyc - busy_hi_cyc, HALF + 3);
    end
    if (dclk) begin hi_run++; last_hi = cyc; end
    else if (p_dclk) begin
      check(hi_run == HALF, "R5 high phase", hi_run, HALF);
      hi_run = 0;
    end
    if (res_valid) begin
      logic [15:0] e;
      check(exp_q.size() > 0, "R7 unexpected strobe", exp_q.size(), 1);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hxxxx;
      check(res_data === e, "R6 result word", res_data, e);
      check(rises == 17, "R5 pulse count", rises, 17);
      check(cyc == last_hi + 1, "R7 strobe timing", cyc, last_hi + 1);
      check(!start_ready, "R2 ready low at strobe", start_ready, 0);
    end
    p_dclk = dclk; p_rc = rc_n; p_busy = conv_busy_n;
  end

  task automatic run_word(input logic [15:0] w, input bit poke);
    model_word = w;
    exp_q.push_back(w);
    n_words++;
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      start_valid = 1'b1;        // must be dropped (R2)
      @(negedge clk);
      start_valid = 1'b0;
      check(!start_ready, "R2 ready stays low", start_ready, 0);
    end
    while (!res_valid) @(negedge clk);
    @(negedge clk);
    check(start_ready && cs_n, "R2 idle after strobe", {start_ready, cs_n}, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(start_ready && cs_n && rc_n && !dclk && !res_valid, "R1 reset outputs",
          {start_ready, cs_n, rc_n, dclk, res_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    check(start_ready && cs_n && rc_n && !dclk && !res_valid, "R1 after release",
          {start_ready, cs_n, rc_n, dclk, res_valid}, 5'b11100);
    run_word(16'h0000, 1'b0);   // edge-1 junk must not appear (R6)
    run_word(16'hFFFF, 1'b1);
    run_word(16'hA5A5, 1'b0);
    run_word(16'h8001, 1'b1);
    run_word(16'h1234, 1'b0);
    run_word(16'h5AA5, 1'b0);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
    check(rc_falls == n_words, "R2 dropped requests", rc_falls, n_words);
    check(quiet_viol == 0, "R4 clock quiet while busy", quiet_viol, 0);
    check(cs_viol == 0, "R3 select held", cs_viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule